// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This block forms the register result of the partial-word "left" and "right" load instructions used to read a word that straddles an alignment boundary. A caller hands it the low bits of the effective address, the aligned memory word already read from that address with those low bits cleared, and the current value of the destination register. It also supplies three selects: which half of the pair to execute, whether memory is big-endian, and whether the operation is a 32-bit word or a 64-bit doubleword. The unit shifts the memory word by the byte offset, keeps the bytes of the old register that the instruction must not touch, and ORs the two together. A left word result is sign-extended and a right word result is zero-extended. Reading memory, writing the register file and raising exceptions are done elsewhere.

The datapath is combinational and ends in one result register. A small two-state output machine tracks whether that register holds a result produced on the previous cycle. In state `ST_EMPTY` the output is not valid. A strobe moves it to `ST_FULL` (transition "capture"), a further strobe keeps it in `ST_FULL` ("refill"), and a cycle without a strobe returns it to `ST_EMPTY` ("drain"). `ST_EMPTY` stays put while no strobe arrives ("idle"). Reset enters `ST_EMPTY`.

Top module: `unaligned_load_merge`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, `out_valid` is 0 and `out_data` is all zeros.
- R2: A strobe on `in_valid` makes `out_valid` 1 on the next cycle, with `out_data` holding that strobe's result. A cycle with no strobe makes `out_valid` 0 on the next cycle and leaves `out_data` unchanged, whatever the other inputs do.
- R3: Left variant (`in_right`=0). Let N be 4 in word mode and 8 in doubleword mode, o the address offset, and s = o if big-endian, else o XOR (N-1). Result byte j (bits 8j+7:8j, 0 ≤ j < N) is memory byte j-s when j ≥ s, and old register byte j when j < s.
- R4: Right variant (`in_right`=1). Let e = o if little-endian, else o XOR (N-1). Result byte j (0 ≤ j < N) is memory byte j+e when j ≤ N-1-e, and old register byte j otherwise.
- R5: In word mode (`in_dword`=0) only bits 31:0 of the memory word and of the old register are used. A left result has bits 63:32 equal to copies of its bit 31.
- R6: In word mode a right result has bits 63:32 equal to zero.
- R7: In doubleword mode all 64 bits follow R3/R4 with no extension. In particular, a left access with s=0 returns the memory word unchanged.
- R8: The offset o is address bits 1:0 in word mode and bits 2:0 in doubleword mode. Address bit 2 has no effect on a word-mode result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: operands are valid this cycle |
| in_ofs_addr | input | OFS_W (3) | Low bits of the effective address |
| in_mem | input | REG_W (64) | Aligned memory word read at the address with the offset bits cleared |
| in_old | input | REG_W (64) | Current destination register value |
| in_right | input | 1 | 0 = left variant, 1 = right variant |
| in_big_endian | input | 1 | 1 = big-endian memory byte order |
| in_dword | input | 1 | 1 = doubleword operation, 0 = word |
| out_valid | output | 1 | Result valid, one cycle after a strobe |
| out_data | output | REG_W (64) | Merged register value |

## Verification
Every offset is exercised for both variants and both byte orders, in word and doubleword mode. Two operand pairs are used: one whose merged bit 31 is set and one where it is clear, so sign extension cannot be confused with zero extension. Each memory and register byte is distinct, so a wrong shift direction, a mask off by one byte, or a swapped byte order lands a visibly wrong byte in a known lane. Further runs set address bit 2 in word mode to show it is ignored, change all inputs without a strobe to show the output holds, and issue back-to-back strobes to confirm that each result appears exactly one cycle after its own strobe.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

    // Width of the word-mode operand.
    localparam int WORD_W   = 32;
    localparam int WORD_SHW = $clog2(WORD_W);

    // Output-stage occupancy.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } state_e;

    // Which half of the partial-load pair is executed.
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } dir_e;

endpackage

// File: rtl/ulm_offset.sv
// Turns the low address bits into a bit shift count. The direction and
// byte order decide whether the byte offset is mirrored inside the lane.
module ulm_offset
    import ulm_pkg::*;
#(
    parameter int REG_W = 64,
    localparam int SHW   = $clog2(REG_W),
    localparam int OFS_W = SHW - 3
) (
    input  logic [OFS_W-1:0] addr_lo,
    input  dir_e             dir,
    input  logic             big_endian,
    input  logic             dword,
    output logic [SHW-1:0]   shamt
);

    logic [OFS_W-1:0] ofs;
    logic [OFS_W-1:0] lane_top;
    logic [OFS_W-1:0] eff;
    logic             mirror;

    generate
        if (REG_W > WORD_W) begin : g_wide
            // Word mode looks at bits 1:0 only; doubleword uses every offset bit.
            always_comb begin
                if (dword) begin
                    ofs      = addr_lo;
                    lane_top = '1;
                end else begin
                    ofs      = {{(OFS_W-2){1'b0}}, addr_lo[1:0]};
                    lane_top = OFS_W'(3);
                end
            end
        end else begin : g_narrow
            always_comb begin
                ofs      = addr_lo;
                lane_top = '1;
            end
        end
    endgenerate

    always_comb begin
        // Left mirrors for little-endian, right mirrors for big-endian.
        mirror = (dir == DIR_RIGHT) ? big_endian : !big_endian;
        eff    = mirror ? (ofs ^ lane_top) : ofs;
        shamt  = {eff, 3'b000};
    end

endmodule

// File: rtl/ulm_shifter.sv
// Moves the memory word into the byte lanes it occupies in the register.
module ulm_shifter
    import ulm_pkg::*;
#(
    parameter int REG_W = 64,
    localparam int SHW  = $clog2(REG_W)
) (
    input  logic [REG_W-1:0] mem,
    input  logic [SHW-1:0]   shamt,
    input  dir_e             dir,
    input  logic             dword,
    output logic [REG_W-1:0] shifted
);

    logic [REG_W-1:0] mem_src;

    generate
        if (REG_W > WORD_W) begin : g_wide
            // A word access behaves as an unsigned 32-bit read.
            always_comb begin
                if (dword) mem_src = mem;
                else       mem_src = {{(REG_W-WORD_W){1'b0}}, mem[WORD_W-1:0]};
            end
        end else begin : g_narrow
            always_comb mem_src = mem;
        end
    endgenerate

    always_comb begin
        if (dir == DIR_RIGHT) shifted = mem_src >> shamt;
        else                  shifted = mem_src << shamt;
    end

endmodule

// File: rtl/ulm_mask.sv
// Builds the mask of old-register bits that survive the merge. The mask is
// a run of ones from a fixed base word, shifted by the inverted shift count.
module ulm_mask
    import ulm_pkg::*;
#(
    parameter int REG_W = 64,
    localparam int SHW  = $clog2(REG_W)
) (
    input  logic [SHW-1:0]   shamt,
    input  dir_e             dir,
    input  logic             dword,
    output logic [REG_W-1:0] keep
);

    localparam logic [WORD_W-1:0] W_LEFT_BASE  = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] W_RIGHT_BASE = {{(WORD_W-1){1'b1}}, 1'b0};

    logic [WORD_SHW-1:0] inv_w;
    logic [WORD_W-1:0]   keep_w;

    always_comb begin
        inv_w  = shamt[WORD_SHW-1:0] ^ WORD_SHW'(WORD_W-1);
        keep_w = (dir == DIR_RIGHT) ? (W_RIGHT_BASE << inv_w)
                                    : (W_LEFT_BASE >> inv_w);
    end

    generate
        if (REG_W > WORD_W) begin : g_wide
            localparam logic [REG_W-1:0] F_LEFT_BASE  = {1'b0, {(REG_W-1){1'b1}}};
            localparam logic [REG_W-1:0] F_RIGHT_BASE = {{(REG_W-1){1'b1}}, 1'b0};

            logic [SHW-1:0]   inv_f;
            logic [REG_W-1:0] keep_f;

            always_comb begin
                inv_f  = shamt ^ SHW'(REG_W-1);
                keep_f = (dir == DIR_RIGHT) ? (F_RIGHT_BASE << inv_f)
                                            : (F_LEFT_BASE >> inv_f);
                // Word mode keeps nothing above bit 31: the extension owns it.
                keep   = dword ? keep_f : {{(REG_W-WORD_W){1'b0}}, keep_w};
            end
        end else begin : g_narrow
            always_comb keep = keep_w;
        end
    endgenerate

endmodule

// File: rtl/unaligned_load_merge.sv
// Partial-word load merge: shifted memory bytes OR surviving register bytes,
// then word-mode extension, captured in one output register.
// REG_W is meant to be 32 or 64.
module unaligned_load_merge
    import ulm_pkg::*;
#(
    parameter int REG_W = 64,
    localparam int SHW   = $clog2(REG_W),
    localparam int OFS_W = SHW - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OFS_W-1:0] in_ofs_addr,
    input  logic [REG_W-1:0] in_mem,
    input  logic [REG_W-1:0] in_old,
    input  logic             in_right,
    input  logic             in_big_endian,
    input  logic             in_dword,
    output logic             out_valid,
    output logic [REG_W-1:0] out_data
);

    dir_e             dir;
    logic             dword_eff;
    logic [SHW-1:0]   shamt;
    logic [REG_W-1:0] shifted;
    logic [REG_W-1:0] keep;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] result;
    logic [REG_W-1:0] data_q;
    state_e           state_q;
    state_e           state_d;

    assign dir = in_right ? DIR_RIGHT : DIR_LEFT;

    generate
        if (REG_W > WORD_W) begin : g_dw
            assign dword_eff = in_dword;
        end else begin : g_nodw
            assign dword_eff = 1'b0;
        end
    endgenerate

    ulm_offset #(.REG_W(REG_W)) u_offset (
        .addr_lo    (in_ofs_addr),
        .dir        (dir),
        .big_endian (in_big_endian),
        .dword      (dword_eff),
        .shamt      (shamt)
    );

    ulm_shifter #(.REG_W(REG_W)) u_shifter (
        .mem     (in_mem),
        .shamt   (shamt),
        .dir     (dir),
        .dword   (dword_eff),
        .shifted (shifted)
    );

    ulm_mask #(.REG_W(REG_W)) u_mask (
        .shamt (shamt),
        .dir   (dir),
        .dword (dword_eff),
        .keep  (keep)
    );

    assign merged = shifted | (in_old & keep);

    // Word-mode extension: sign for left, zero for right.
    generate
        if (REG_W > WORD_W) begin : g_ext
            always_comb begin
                if (dword_eff)
                    result = merged;
                else if (dir == DIR_RIGHT)
                    result = {{(REG_W-WORD_W){1'b0}}, merged[WORD_W-1:0]};
                else
                    result = {{(REG_W-WORD_W){merged[WORD_W-1]}}, merged[WORD_W-1:0]};
            end
        end else begin : g_noext
            always_comb result = merged;
        end
    endgenerate

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state: capture / refill / drain / idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
            default:                 state_d = ST_EMPTY;
        endcase
    end

    // Result register: loads only on a strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (in_valid) data_q <= result;
    end

    // Outputs.
    always_comb begin
        out_valid = (state_q == ST_FULL);
        out_data  = data_q;
    end

    // ---------------- assertions ----------------

    // R2: a strobe yields a valid result on the next cycle.
    p_strobe_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe means no valid and an unchanged result.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R3 / R4: shifted memory bits never overlap the kept register bits.
    p_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shifted & keep) == '0);

    generate
        if (REG_W > WORD_W) begin : g_ext_chk
            // R5: a word left result is sign-extended from bit 31.
            p_sext_word_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_dword && !in_right) |=>
                (out_data[REG_W-1:WORD_W] == {(REG_W-WORD_W){out_data[WORD_W-1]}}));

            // R6: a word right result has zero upper bits.
            p_zext_word_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_dword && in_right) |=>
                (out_data[REG_W-1:WORD_W] == '0));

            // R7: a doubleword left access with zero effective offset returns memory.
            p_full_replace_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_dword && !in_right &&
                 ((in_ofs_addr ^ {OFS_W{!in_big_endian}}) == '0)) |=>
                (out_data == $past(in_mem)));
        end
    endgenerate

endmodule

// File: tb/unaligned_load_merge_bench.sv
`timescale 1ns/1ps
module unaligned_load_merge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_ofs_addr = '0;
    logic [63:0] in_mem = '0;
    logic [63:0] in_old = '0;
    logic        in_right = 1'b0;
    logic        in_big_endian = 1'b0;
    logic        in_dword = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    unaligned_load_merge u_unaligned_load_merge (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ofs_addr   (in_ofs_addr),
        .in_mem        (in_mem),
        .in_old        (in_old),
        .in_right      (in_right),
        .in_big_endian (in_big_endian),
        .in_dword      (in_dword),
        .out_valid     (out_valid),
        .out_data      (out_data)
    );

    // Byte-lane reference built from the requirement text.
    function automatic logic [63:0] ref_merge(input logic [2:0] a, input logic [63:0] mem,
                                              input logic [63:0] old, input logic right,
                                              input logic be, input logic dw);
        int n;
        int o;
        int s;
        logic [63:0] r;
        n = dw ? 8 : 4;
        o = dw ? int'(a) : int'(a[1:0]);
        r = '0;
        if (!right) s = be ? o : (o ^ (n - 1));
        else        s = be ? (o ^ (n - 1)) : o;
        for (int j = 0; j < n; j++) begin
            if (!right) begin
                if (j >= s) r[8*j +: 8] = mem[8*(j-s) +: 8];
                else        r[8*j +: 8] = old[8*j +: 8];
            end else begin
                if (j <= n - 1 - s) r[8*j +: 8] = mem[8*(j+s) +: 8];
                else                r[8*j +: 8] = old[8*j +: 8];
            end
        end
        if (!dw) r[63:32] = right ? 32'h0 : {32{r[31]}};
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One strobe, then check the registered result one cycle later.
    task automatic run_op(input logic [2:0] a, input logic [63:0] mem, input logic [63:0] old,
                          input logic right, input logic be, input logic dw,
                          input logic [63:0] exp, input string tag);
        @(negedge clk);
        in_ofs_addr = a; in_mem = mem; in_old = old;
        in_right = right; in_big_endian = be; in_dword = dw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 valid"}, {63'b0, out_valid}, 64'd1);
        chk(tag, out_data, exp);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {63'b0, out_valid}, 64'd0);
        chk("R1 data in reset", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {63'b0, out_valid}, 64'd0);
        chk("R1 data after reset", out_data, 64'd0);
    endtask

    task automatic t_word_sweep(input logic [63:0] mem, input logic [63:0] old);
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < 4; a++)
                    run_op(3'(a), mem, old, 1'(r), 1'(b), 1'b0,
                           ref_merge(3'(a), mem, old, 1'(r), 1'(b), 1'b0),
                           $sformatf("%s word dir=%0d be=%0d ofs=%0d",
                                     r ? "R4/R6" : "R3/R5", r, b, a));
    endtask

    task automatic t_dword_sweep(input logic [63:0] mem, input logic [63:0] old);
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < 8; a++)
                    run_op(3'(a), mem, old, 1'(r), 1'(b), 1'b1,
                           ref_merge(3'(a), mem, old, 1'(r), 1'(b), 1'b1),
                           $sformatf("%s R7 dword dir=%0d be=%0d ofs=%0d",
                                     r ? "R4" : "R3", r, b, a));
    endtask

    // R8: address bit 2 must not change a word result.
    task automatic t_word_bit2(input logic [63:0] mem, input logic [63:0] old);
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < 4; a++)
                run_op(3'(a + 4), mem, old, 1'(r), 1'b1, 1'b0,
                       ref_merge(3'(a), mem, old, 1'(r), 1'b1, 1'b0),
                       $sformatf("R8 word bit2 set dir=%0d ofs=%0d", r, a));
    endtask

    // R2: without a strobe the output holds even as inputs change.
    task automatic t_hold;
        logic [63:0] exp;
        exp = ref_merge(3'd5, 64'h0F1E_2D3C_4B5A_6978, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 1'b1, 1'b1);
        run_op(3'd5, 64'h0F1E_2D3C_4B5A_6978, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 1'b1, 1'b1,
               exp, "R3 hold setup");
        in_ofs_addr = 3'd2; in_mem = 64'h1234_5678_9ABC_DEF0; in_old = '1;
        in_right = 1'b1; in_dword = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 hold valid low", {63'b0, out_valid}, 64'd0);
        chk("R2 hold data", out_data, exp);
    endtask

    // R2: consecutive strobes each land exactly one cycle later.
    task automatic t_back_to_back;
        logic [63:0] e1;
        logic [63:0] e2;
        e1 = ref_merge(3'd1, 64'h8877_6655_4433_2211, 64'hF0E1_D2C3_B4A5_9687, 1'b0, 1'b0, 1'b0);
        e2 = ref_merge(3'd6, 64'h8877_6655_4433_2211, 64'hF0E1_D2C3_B4A5_9687, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        in_ofs_addr = 3'd1; in_mem = 64'h8877_6655_4433_2211; in_old = 64'hF0E1_D2C3_B4A5_9687;
        in_right = 1'b0; in_big_endian = 1'b0; in_dword = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk("R2 b2b first valid", {63'b0, out_valid}, 64'd1);
        chk("R2/R3 b2b first data", out_data, e1);
        in_ofs_addr = 3'd6; in_right = 1'b1; in_dword = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second valid", {63'b0, out_valid}, 64'd1);
        chk("R2/R4 b2b second data", out_data, e2);
        @(negedge clk);
        chk("R2 b2b drain", {63'b0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_word_sweep(64'h8877_6655_C433_2291, 64'hF0E1_D2C3_B4A5_9687);
        t_word_sweep(64'h0102_0304_7A6B_5C4D, 64'h1324_3546_5768_F9EA);
        t_dword_sweep(64'h8877_6655_4433_2211, 64'hF0E1_D2C3_B4A5_9687);
        t_word_bit2(64'h8877_6655_C433_2291, 64'h1324_3546_5768_F9EA);
        t_hold();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule